// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device-side walker for a ring of transmit descriptors kept in system memory. Software fills 8-byte descriptors and then writes a control word with bit 0 set. The engine reads each descriptor through a single-outstanding word port and hands the buffer address and byte count to a MAC over a valid/ready frame channel. It then waits for the MAC's completion report. Once the report arrives, the engine writes the descriptor's flag word back in place, with the ownership bit cleared and the completion status merged in, and pulses either a success or an error interrupt.

Each descriptor holds two words. The word at offset 0 is the buffer's physical address. The word at offset 4 is the flag word, with these fields:
- bit 31: hardware owns the entry.
- bit 16: last fragment of the packet.
- bits 10:0: byte count minus one.
- bit 19: retry error.
- bit 26: deferred.
- bit 27: carrier lost.
- bit 28: late collision.
- bit 29: underflow.
- bit 30: any error.

The engine advances through the ring until it meets an entry it does not own. It then goes idle and keeps its position for the next kick. Payload movement, MAC timing and bus fabric lie outside this block.

Top module: `txr_dma_engine`

## Requirements
- R1: While reset is asserted, and after its release until the first kick, the engine makes no memory request, offers no frame and raises no interrupt pulse.
- R2: A control write with bit 0 set starts a walk at the current ring index. A control write with bit 0 clear has no effect. A memory request holds its address and direction until acknowledged.
- R3: Descriptor entry i sits at base + 8*i. The frame offered to the MAC carries address = word 0, length = flag[10:0] + 1 and last = flag[16]. The frame stays stable until accepted.
- R4: The engine reads the flag word first. An entry whose flag bit 31 is clear is neither sent nor written. The walk stops there.
- R5: After each completion, the flag word is written back to the same entry with these changes:
  - bit 31 is cleared.
  - MAC error code bits 0..4 (retry, deferred, carrier lost, late collision, underflow) are placed in flag bits 19, 26, 27, 28 and 29.
  - bit 30 is set to the OR of those error bits.
  - All other bits are preserved.
- R6: Each write-back is followed, one cycle after its acknowledge, by exactly one single-cycle pulse. The pulse is on tx_ok when the MAC reported no error, and on tx_err otherwise.
- R7: The ring holds ring_sizes[15:0] + 1 entries. After the last entry the index wraps to 0, the ring base.
- R8: The ring index persists across idle periods, so the next kick resumes at the entry that stopped the previous walk.
- R9: Writing a new ring base resets the ring index to 0.
- R10: A kick that arrives while a walk is in progress is remembered. If the walk then stops at a non-owned entry, that entry's flag is read again.
- R11: Bits 31:16 of the ring size input have no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_wr | input | 1 | Strobe: load a new ring base |
| cfg_base | input | AW | Ring base byte address |
| cfg_ring_sizes | input | 32 | Bits 15:0 hold transmit entry count minus one; bits 31:16 are ignored |
| ctl_wr | input | 1 | Strobe: control register write |
| ctl_wdata | input | 32 | Control data; bit 0 is the kick |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word byte address |
| mem_wdata | output | 32 | Write data (flag write-back) |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| frm_valid | output | 1 | Frame request valid |
| frm_ready | input | 1 | MAC accepts frame request |
| frm_addr | output | 32 | Buffer address of the frame |
| frm_len | output | 12 | Frame length in bytes (1..2048) |
| frm_last | output | 1 | Last fragment of packet |
| done_valid | input | 1 | MAC completion strobe |
| done_err | input | 5 | Error code: retry, deferred, carrier lost, late collision, underflow (bits 0..4) |
| tx_ok_pulse | output | 1 | Interrupt pulse: error-free frame written back |
| tx_err_pulse | output | 1 | Interrupt pulse: errored frame written back |

## Verification
The bench builds the engine with AW = 32 and IDX_W = 8, and programs a four-entry ring at run time, so the wrap from the last entry back to the base takes only a few frames. Its memory model has a latency that can be changed at run time. Raising that latency to 30 cycles keeps a flag read in flight long enough to make a descriptor valid and kick again before the stale data returns, which is how the remembered kick is exercised. The upper half of the ring size input is loaded with junk throughout.

// File: rtl/txr_pkg.sv
package txr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_FLAG,
      ST_RD_ADDR,
      ST_SEND,
      ST_WAIT,
      ST_WB
   } txr_state_e;

   localparam int OWN_BIT     = 31;
   localparam int SUM_ERR_BIT = 30;
   localparam int LAST_BIT    = 16;
   localparam int LEN_W       = 11;
   localparam int NUM_ERR     = 5;
   localparam int SZ_FIELD_W  = 16;
   // flag positions of MAC error code bits 0..4
   localparam int ERR_POS [NUM_ERR] = '{19, 26, 27, 28, 29};
endpackage

// File: rtl/txr_wb_merge.sv
module txr_wb_merge
   import txr_pkg::*;
(
   input  logic [31:0]        flag_in,
   input  logic [NUM_ERR-1:0] err,
   output logic [31:0]        flag_out,
   output logic               err_any
);
   logic [31:0] sts_mask;
   logic [31:0] sts_val;

   always_comb begin
      sts_mask = '0;
      sts_val  = '0;
      for (int i = 0; i < NUM_ERR; i++) begin
         sts_mask[ERR_POS[i]] = 1'b1;
         sts_val[ERR_POS[i]]  = err[i];
      end
      sts_mask[SUM_ERR_BIT] = 1'b1;
      sts_mask[OWN_BIT]     = 1'b1;
      sts_val[SUM_ERR_BIT]  = |err;
      flag_out = (flag_in & ~sts_mask) | sts_val;
   end

   assign err_any = |err;
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_wr,
   input  logic             adv,
   input  logic [IDX_W-1:0] last_idx,
   output logic [IDX_W-1:0] idx
);
   generate
      if (IDX_W < 1 || IDX_W > 16) begin : g_bad_w
         $error("txr_ring_ptr: IDX_W must lie in 1..16");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (base_wr)
         idx <= '0;
      else if (adv)
         idx <= (idx == last_idx) ? '0 : idx + 1'b1;
   end

   // R9
   base_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_wr |=> idx == '0);

   // R7
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !base_wr && idx == last_idx) |=> idx == '0);

   // R8
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !base_wr && idx != last_idx) |=> idx == $past(idx) + 1'b1);
endmodule

// File: rtl/txr_kick_latch.sv
module txr_kick_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         pend <= 1'b0;
      else if (clr)
         pend <= 1'b0;
      else if (set)
         pend <= 1'b1;
   end

   // R10
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr) |=> pend);
endmodule

// File: rtl/txr_dma_engine.sv
module txr_dma_engine
   import txr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int IDX_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_base_wr,
   input  logic [AW-1:0]      cfg_base,
   input  logic [31:0]        cfg_ring_sizes,
   input  logic               ctl_wr,
   input  logic [31:0]        ctl_wdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [AW-1:0]      mem_addr,
   output logic [31:0]        mem_wdata,
   input  logic               mem_ack,
   input  logic [31:0]        mem_rdata,
   output logic               frm_valid,
   input  logic               frm_ready,
   output logic [31:0]        frm_addr,
   output logic [LEN_W:0]     frm_len,
   output logic               frm_last,
   input  logic               done_valid,
   input  logic [NUM_ERR-1:0] done_err,
   output logic               tx_ok_pulse,
   output logic               tx_err_pulse
);
   localparam int OFF_W = IDX_W + 3;
   localparam logic [AW-1:0] FLAG_OFS = AW'(4);

   generate
      if (IDX_W > SZ_FIELD_W) begin : g_bad_idx
         $error("txr_dma_engine: IDX_W exceeds ring size field");
      end
      if (AW < OFF_W) begin : g_bad_aw
         $error("txr_dma_engine: AW too narrow for ring offsets");
      end
   endgenerate

   txr_state_e         state_q, state_d;
   logic [AW-1:0]      base_q;
   logic [31:0]        flag_q;
   logic [31:0]        addr_q;
   logic [NUM_ERR-1:0] err_q;
   logic [IDX_W-1:0]   idx;
   logic [AW-1:0]      desc_addr;
   logic [31:0]        wb_flag;
   logic               err_any;
   logic               kick, pend, consume, adv;
   logic               unused_in;

   assign unused_in = ^{cfg_ring_sizes, ctl_wdata[31:1]};
   assign kick      = ctl_wr & ctl_wdata[0];
   assign adv       = (state_q == ST_WB) && mem_ack;
   assign consume   = (state_q == ST_RD_FLAG) && mem_ack &&
                      !mem_rdata[OWN_BIT] && (pend || kick);

   txr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .base_wr  (cfg_base_wr),
      .adv      (adv),
      .last_idx (cfg_ring_sizes[IDX_W-1:0]),
      .idx      (idx)
   );

   txr_kick_latch u_kick (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (kick && state_q != ST_IDLE),
      .clr   (consume),
      .pend  (pend)
   );

   txr_wb_merge u_merge (
      .flag_in  (flag_q),
      .err      (err_q),
      .flag_out (wb_flag),
      .err_any  (err_any)
   );

   assign desc_addr = base_q + {{(AW-OFF_W){1'b0}}, idx, 3'b000};

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (kick) state_d = ST_RD_FLAG;
         ST_RD_FLAG: if (mem_ack) begin
                        if (mem_rdata[OWN_BIT])   state_d = ST_RD_ADDR;
                        else if (!(pend || kick)) state_d = ST_IDLE;
                     end
         ST_RD_ADDR: if (mem_ack)    state_d = ST_SEND;
         ST_SEND:    if (frm_ready)  state_d = ST_WAIT;
         ST_WAIT:    if (done_valid) state_d = ST_WB;
         ST_WB:      if (mem_ack)    state_d = ST_RD_FLAG;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         base_q       <= '0;
         flag_q       <= '0;
         addr_q       <= '0;
         err_q        <= '0;
         tx_ok_pulse  <= 1'b0;
         tx_err_pulse <= 1'b0;
      end else begin
         state_q <= state_d;
         if (cfg_base_wr)
            base_q <= cfg_base;
         if (state_q == ST_RD_FLAG && mem_ack)
            flag_q <= mem_rdata;
         if (state_q == ST_RD_ADDR && mem_ack)
            addr_q <= mem_rdata;
         if (state_q == ST_WAIT && done_valid)
            err_q <= done_err;
         tx_ok_pulse  <= adv && !err_any;
         tx_err_pulse <= adv && err_any;
      end
   end

   assign mem_req   = (state_q == ST_RD_FLAG) || (state_q == ST_RD_ADDR) ||
                      (state_q == ST_WB);
   assign mem_we    = (state_q == ST_WB);
   assign mem_addr  = (state_q == ST_RD_ADDR) ? desc_addr : desc_addr + FLAG_OFS;
   assign mem_wdata = wb_flag;

   assign frm_valid = (state_q == ST_SEND);
   assign frm_addr  = addr_q;
   assign frm_len   = {1'b0, flag_q[LEN_W-1:0]} + 1'b1;
   assign frm_last  = flag_q[LAST_BIT];

   // R2
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R3
   frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_addr) && $stable(frm_len)));

   // R5
   wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

   // R6
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_ok_pulse && tx_err_pulse));

   // R6
   irq_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ok_pulse || tx_err_pulse) |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: tb/tb_txr_dma_engine.sv
module tb_txr_dma_engine;
   import txr_pkg::*;

   localparam int AW = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_base_wr = 1'b0;
   logic [AW-1:0]      cfg_base = '0;
   logic [31:0]        cfg_ring_sizes = '0;
   logic               ctl_wr = 1'b0;
   logic [31:0]        ctl_wdata = '0;
   logic               mem_req, mem_we;
   logic [AW-1:0]      mem_addr;
   logic [31:0]        mem_wdata;
   logic               mem_ack;
   logic [31:0]        mem_rdata;
   logic               frm_valid, frm_ready;
   logic [31:0]        frm_addr;
   logic [LEN_W:0]     frm_len;
   logic               frm_last;
   logic               done_valid;
   logic [NUM_ERR-1:0] done_err;
   logic               tx_ok_pulse, tx_err_pulse;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   txr_dma_engine #(.AW(AW), .IDX_W(8)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_base_wr(cfg_base_wr), .cfg_base(cfg_base), .cfg_ring_sizes(cfg_ring_sizes),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_addr(frm_addr),
      .frm_len(frm_len), .frm_last(frm_last),
      .done_valid(done_valid), .done_err(done_err),
      .tx_ok_pulse(tx_ok_pulse), .tx_err_pulse(tx_err_pulse)
   );

   // memory model: snapshot at acceptance, acknowledge after lat cycles
   logic [31:0] mem [0:255];
   int          lat = 1;
   int          mcnt = 0;
   logic        mbusy = 1'b0;
   int          n_memops = 0;

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (!rst_n) begin
         mbusy <= 1'b0;
      end else if (mem_req && !mem_ack && !mbusy) begin
         mbusy     <= 1'b1;
         mcnt      <= lat;
         n_memops  <= n_memops + 1;
         mem_rdata <= mem[mem_addr[9:2]];
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      end else if (mbusy) begin
         if (mcnt <= 1) begin
            mem_ack <= 1'b1;
            mbusy   <= 1'b0;
         end else begin
            mcnt <= mcnt - 1;
         end
      end
   end

   // MAC model with frame log
   logic [31:0]        log_addr [0:31];
   logic [LEN_W:0]     log_len  [0:31];
   logic               log_last [0:31];
   logic [NUM_ERR-1:0] err_seq  [0:31];
   logic [NUM_ERR-1:0] cur_err = '0;
   int                 n_frames = 0;
   int                 dly = 0;
   int                 n_ok = 0;
   int                 n_err = 0;

   assign done_err = cur_err;

   always @(posedge clk) begin
      if (!rst_n) begin
         frm_ready  <= 1'b0;
         done_valid <= 1'b0;
         dly        <= 0;
      end else begin
         frm_ready  <= frm_valid && !frm_ready;
         done_valid <= 1'b0;
         if (frm_valid && frm_ready) begin
            log_addr[n_frames] <= frm_addr;
            log_len[n_frames]  <= frm_len;
            log_last[n_frames] <= frm_last;
            cur_err            <= err_seq[n_frames];
            n_frames           <= n_frames + 1;
            dly                <= 3;
         end else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) done_valid <= 1'b1;
         end
         if (tx_ok_pulse)  n_ok  <= n_ok + 1;
         if (tx_err_pulse) n_err <= n_err + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_wb(input logic [31:0] f, input logic [4:0] e);
      logic [31:0] r;
      r = f & ~32'hFC08_0000;
      if (e[0]) r |= 32'h0008_0000;
      if (e[1]) r |= 32'h0400_0000;
      if (e[2]) r |= 32'h0800_0000;
      if (e[3]) r |= 32'h1000_0000;
      if (e[4]) r |= 32'h2000_0000;
      if (e != 0) r |= 32'h4000_0000;
      return r;
   endfunction

   task automatic ctl_write(input logic [31:0] d);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic base_write(input logic [31:0] b);
      @(negedge clk);
      cfg_base_wr = 1'b1; cfg_base = b;
      @(negedge clk);
      cfg_base_wr = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 20) begin
         @(negedge clk);
         if (mem_req || frm_valid) q = 0;
         else q++;
      end
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(!mem_req && !frm_valid && !tx_ok_pulse && !tx_err_pulse, "R1",
          "outputs in reset", {mem_req, frm_valid, tx_ok_pulse, tx_err_pulse}, 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(n_memops == 0 && n_frames == 0, "R1", "activity before kick",
          n_memops + n_frames, 0);
   endtask

   task automatic t_basic();
      cfg_ring_sizes = 32'hABCD_0003;   // R11: junk in upper half, 4 entries
      base_write(32'h100);
      mem[64] = 32'h0000_2000; mem[65] = 32'h8801_0063;
      mem[66] = 32'h0000_3004; mem[67] = 32'h8000_0000;
      mem[68] = 32'h0000_5000; mem[69] = 32'h0000_0010;
      mem[70] = 32'h0000_6000; mem[71] = 32'h0000_0000;
      ctl_write(32'h0000_0002);
      wait_quiet();
      chk(n_memops == 0 && n_frames == 0, "R2", "write without kick bit",
          n_memops + n_frames, 0);
      ctl_write(32'h0000_0001);
      wait_quiet();
      chk(n_frames == 2, "R4", "frames before non-owned entry", n_frames, 2);
      chk(log_addr[0] == 32'h2000 && log_len[0] == 100 && log_last[0], "R3",
          "frame0 addr", log_addr[0], 32'h2000);
      chk(log_len[0] == 100, "R3", "frame0 length", log_len[0], 100);
      chk(log_addr[1] == 32'h3004 && log_len[1] == 1 && !log_last[1], "R3",
          "frame1 len/last", {log_len[1], 3'b0, log_last[1]}, {12'd1, 4'b0});
      chk(mem[65] == exp_wb(32'h8801_0063, 0), "R5", "frame0 write-back",
          mem[65], exp_wb(32'h8801_0063, 0));
      chk(mem[67] == 32'h0, "R5", "frame1 write-back", mem[67], 0);
      chk(mem[69] == 32'h10, "R4", "non-owned entry untouched", mem[69], 32'h10);
      chk(n_ok == 2 && n_err == 0, "R6", "ok pulses", n_ok, 2);
      chk(n_err == 0, "R11", "upper size bits ignored, no error", n_err, 0);
   endtask

   task automatic t_err_wrap();
      mem[68] = 32'h0000_5000; mem[69] = 32'h8001_05FF;
      err_seq[2] = 5'b10001;
      mem[70] = 32'h0000_6000; mem[71] = 32'h8001_0000;
      err_seq[3] = 5'b00000;
      ctl_write(32'h1);
      wait_quiet();
      chk(n_frames == 4, "R8", "resume count", n_frames, 4);
      chk(log_addr[2] == 32'h5000, "R8", "resume at stopped entry", log_addr[2], 32'h5000);
      chk(log_len[2] == 12'd1536, "R3", "frame2 length", log_len[2], 1536);
      chk(mem[69] == exp_wb(32'h8001_05FF, 5'b10001), "R5", "errored write-back",
          mem[69], exp_wb(32'h8001_05FF, 5'b10001));
      chk(mem[71] == 32'h0001_0000, "R5", "clean write-back keeps last bit",
          mem[71], 32'h0001_0000);
      chk(n_err == 1 && n_ok == 3, "R6", "error pulse count", n_err, 1);
      mem[64] = 32'h0000_7000; mem[65] = 32'h8001_000F;
      err_seq[4] = 5'b00100;
      ctl_write(32'h1);
      wait_quiet();
      chk(n_frames == 5 && log_addr[4] == 32'h7000, "R7", "wrap to base",
          log_addr[4], 32'h7000);
      chk(mem[65] == exp_wb(32'h8001_000F, 5'b00100), "R5", "carrier write-back",
          mem[65], exp_wb(32'h8001_000F, 5'b00100));
      chk(n_err == 2, "R6", "second error pulse", n_err, 2);
   endtask

   task automatic t_rebase_late_kick();
      base_write(32'h180);
      mem[96] = 32'h0000_8000; mem[97] = 32'h0000_0000;
      mem[98] = 32'h0000_0000; mem[99] = 32'h0000_0000;
      mem[100] = 32'h0000_0000; mem[101] = 32'h0000_0000;
      lat = 30;
      ctl_write(32'h1);
      repeat (5) @(negedge clk);
      mem[97] = 32'h8001_0007;
      ctl_write(32'h1);
      wait_quiet();
      lat = 1;
      chk(n_frames == 6, "R10", "kick during stale read", n_frames, 6);
      chk(log_addr[5] == 32'h8000, "R9", "index reset by new base", log_addr[5], 32'h8000);
      chk(log_len[5] == 8 && log_last[5], "R3", "frame5 len", log_len[5], 8);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int i = 0; i < 32; i++) err_seq[i] = '0;
      t_reset();
      t_basic();
      t_err_wrap();
      t_rebase_late_kick();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule